// File: doc/BRIEF.md
# Program Sequencer with Hardware Return Stack

This block is the next-instruction engine of a small register-machine core. It takes one decoded control operation per accepted cycle, together with its operands (a jump target, two register values, an immediate), and from them keeps the program counter, a one-bit equality flag and a hardware return stack for subroutine call and return. Fetch, decode, the register file and the arithmetic unit sit outside the block. The sequencer only sees operation codes and operand values.

The flag comes from equality compares only. Conditional jumps test it for zero or nonzero. A third compare form leaves the flag alone and instead produces a 0/1 result word, which the core writes to a destination register. The return stack has a discard operation that pops the newest entry without jumping. A push onto a full stack, or a pop from an empty one, does not move the stack pointer. It sets a sticky error bit and the operation falls through to the next index.

Control is a two-state machine. In state RUN, an accepted operation updates the counter. The transition RUN to HALT happens on an accepted halt operation. State HALT only leaves (HALT to RUN) through synchronous reset. While in HALT, every input is ignored.

Top module: `prog_seq`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears pc, flag, halted, stk_err and res_we, empties the return stack and puts the machine in RUN.
- R2: When op_valid is low, pc, flag and stk_err hold. An accepted op with code 0 (no-op), or with any code from 11 to 15, advances pc by one (modulo 2^PC_W) and changes nothing else.
- R3: Code 1 (compare immediate) sets flag to 1 if op_ra equals op_imm and to 0 otherwise, and advances pc by one.
- R4: Code 2 (compare registers) sets flag to 1 if op_ra equals op_rb and to 0 otherwise, and advances pc by one.
- R5: Code 3 (compare into register) raises res_we for exactly one cycle after acceptance, with res_data = 1 if op_ra equals op_rb and 0 otherwise. It leaves flag unchanged and advances pc by one.
- R6: Code 4 (jump) loads op_target into pc.
- R7: Code 5 loads op_target when flag is 1, code 6 loads op_target when flag is 0. Otherwise either one advances pc by one.
- R8: Code 7 (call) pushes the current pc and loads op_target. Code 8 (return) pops the newest entry E and sets pc to E+1.
- R9: Code 9 (discard) pops the newest return entry and advances pc by one, without jumping.
- R10: The stack holds DEPTH (16) entries. A call when 16 entries are held, or a return or discard when none are held, leaves the stack unchanged, sets the sticky stk_err, and advances pc by one.
- R11: Code 10 (halt) sets halted, keeps pc unchanged, and from then on pc, flag, the stack and res_we ignore every op until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Decoded operation code |
| op_target | input | PC_W | Jump or call target index |
| op_ra | input | DATA_W | First register operand |
| op_rb | input | DATA_W | Second register operand |
| op_imm | input | DATA_W | Immediate operand |
| pc | output | PC_W | Current instruction index |
| flag | output | 1 | Equality flag |
| halted | output | 1 | Machine is in HALT |
| stk_err | output | 1 | Sticky return-stack overflow/underflow |
| res_we | output | 1 | Compare-into-register result valid |
| res_data | output | DATA_W | Compare-into-register result (0 or 1) |

## Verification
Every output is a register, so the result of an op accepted at one rising edge is visible right after that edge, and it stays there until the next accepted op. The bench drives each op on a falling edge, keeps it valid for one rising edge, and compares all six outputs against its own model at the next falling edge, half a cycle after the update. Ops are issued back to back, so an extra idle falling edge confirms that res_we has dropped and the counter holds.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_CMPI = 4'd1,
        OP_CMPR = 4'd2,
        OP_CMP3 = 4'd3,
        OP_JMP  = 4'd4,
        OP_JNZ  = 4'd5,
        OP_JZ   = 4'd6,
        OP_CALL = 4'd7,
        OP_RET  = 4'd8,
        OP_DROP = 4'd9,
        OP_HALT = 4'd10
    } seq_op_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/seq_cmp.sv
module seq_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] ra,
    input  logic [DATA_W-1:0] rb,
    input  logic [DATA_W-1:0] imm,
    output logic              eq_imm,
    output logic              eq_reg
);
    // Pure equality; no magnitude compare in this machine.
    assign eq_imm = (ra == imm);
    assign eq_reg = (ra == rb);
endmodule

// File: rtl/seq_retstack.sv
module seq_retstack #(
    parameter int PC_W  = 8,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_req,
    input  logic            pop_req,
    input  logic [PC_W-1:0] push_data,
    output logic [PC_W-1:0] top,
    output logic            full,
    output logic            empty,
    output logic            err
);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] SP_FULL = PTR_W'(DEPTH);

    logic [PTR_W-1:0] sp;
    logic [PC_W-1:0]  ent [DEPTH];
    logic             do_push;
    logic             do_pop;
    logic [IDX_W-1:0] top_idx;

    assign full    = (sp == SP_FULL);
    assign empty   = (sp == '0);
    assign do_push = push_req && !full;
    assign do_pop  = pop_req && !empty;
    assign top_idx = IDX_W'(sp - 1'b1);
    assign top     = ent[top_idx];

    // One storage slot per entry; only the slot at the pointer loads.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (sp == PTR_W'(i))) begin
                ent[i] <= push_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp  <= '0;
            err <= 1'b0;
        end else begin
            if (do_push) begin
                sp <= sp + 1'b1;
            end else if (do_pop) begin
                sp <= sp - 1'b1;
            end
            if ((push_req && full) || (pop_req && empty)) begin
                err <= 1'b1;
            end
        end
    end

    p_ptr_range_r10: assert property (@(posedge clk) disable iff (rst)
        sp <= SP_FULL);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (push_req && full) |=> (sp == $past(sp)) && err);

    p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty) |=> (sp == $past(sp)) && err);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    p_push_grow_r8: assert property (@(posedge clk) disable iff (rst)
        (push_req && !full) |=> (sp == $past(sp) + 1'b1));

    p_pop_shrink_r9: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !empty) |=> (sp == $past(sp) - 1'b1));

    p_req_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(push_req && pop_req));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import prog_seq_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  seq_op_e         op,
    input  logic [PC_W-1:0] op_target,
    input  logic            eq_imm,
    input  logic            eq_reg,
    input  logic [PC_W-1:0] stk_top,
    input  logic            stk_full,
    input  logic            stk_empty,
    output logic [PC_W-1:0] pc,
    output logic            flag,
    output logic            halted,
    output logic            push_req,
    output logic            pop_req,
    output logic            res_we,
    output logic            res_bit
);
    seq_state_e      state, state_nxt;
    logic            accept;
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] pc_nxt;
    logic            flag_nxt;
    logic            we_nxt;
    logic            bit_nxt;

    assign accept = op_valid && (state == ST_RUN);
    assign pc_inc = pc + 1'b1;
    assign halted = (state == ST_HALT);

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:  if (accept && (op == OP_HALT)) state_nxt = ST_HALT;
            ST_HALT: state_nxt = ST_HALT;
            default: state_nxt = ST_RUN;
        endcase
    end

    // Datapath decisions for the accepted operation
    always_comb begin
        pc_nxt   = pc;
        flag_nxt = flag;
        we_nxt   = 1'b0;
        bit_nxt  = res_bit;
        push_req = 1'b0;
        pop_req  = 1'b0;
        if (accept) begin
            unique case (op)
                OP_CMPI: begin
                    flag_nxt = eq_imm;
                    pc_nxt   = pc_inc;
                end
                OP_CMPR: begin
                    flag_nxt = eq_reg;
                    pc_nxt   = pc_inc;
                end
                OP_CMP3: begin
                    we_nxt  = 1'b1;
                    bit_nxt = eq_reg;
                    pc_nxt  = pc_inc;
                end
                OP_JMP:  pc_nxt = op_target;
                OP_JNZ:  pc_nxt = flag ? op_target : pc_inc;
                OP_JZ:   pc_nxt = flag ? pc_inc : op_target;
                OP_CALL: begin
                    push_req = 1'b1;
                    pc_nxt   = stk_full ? pc_inc : op_target;
                end
                OP_RET: begin
                    pop_req = 1'b1;
                    pc_nxt  = stk_empty ? pc_inc : stk_top + 1'b1;
                end
                OP_DROP: begin
                    pop_req = 1'b1;
                    pc_nxt  = pc_inc;
                end
                OP_HALT: pc_nxt = pc;
                default: pc_nxt = pc_inc;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
        end else begin
            state <= state_nxt;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            flag    <= 1'b0;
            res_we  <= 1'b0;
            res_bit <= 1'b0;
        end else begin
            pc      <= pc_nxt;
            flag    <= flag_nxt;
            res_we  <= we_nxt;
            res_bit <= bit_nxt;
        end
    end

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(pc) && $stable(flag) && !res_we);

    p_nop_step_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_NOP) |=> (pc == $past(pc) + 1'b1) && $stable(flag));

    p_cmp3_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_CMP3) |=> $stable(flag) && res_we);

    p_jump_load_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_JMP) |=> (pc == $past(op_target)));

    p_ret_resume_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_RET && !stk_empty) |=> (pc == $past(stk_top) + 1'b1));

    p_drop_step_r9: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_DROP) |=> (pc == $past(pc) + 1'b1));

    p_halt_freeze_r11: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(pc) && $stable(flag) && !res_we);

    p_halt_no_stack_r11: assert property (@(posedge clk) disable iff (rst)
        halted |-> !push_req && !pop_req);

endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import prog_seq_pkg::*;
#(
    parameter int PC_W   = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [PC_W-1:0]   op_target,
    input  logic [DATA_W-1:0] op_ra,
    input  logic [DATA_W-1:0] op_rb,
    input  logic [DATA_W-1:0] op_imm,
    output logic [PC_W-1:0]   pc,
    output logic              flag,
    output logic              halted,
    output logic              stk_err,
    output logic              res_we,
    output logic [DATA_W-1:0] res_data
);
    logic            eq_imm;
    logic            eq_reg;
    logic            push_req;
    logic            pop_req;
    logic [PC_W-1:0] stk_top;
    logic            stk_full;
    logic            stk_empty;
    logic            res_bit;
    seq_op_e         op;

    assign op       = seq_op_e'(op_code);
    assign res_data = DATA_W'(res_bit);

    seq_cmp #(.DATA_W(DATA_W)) u_cmp (
        .ra     (op_ra),
        .rb     (op_rb),
        .imm    (op_imm),
        .eq_imm (eq_imm),
        .eq_reg (eq_reg)
    );

    seq_retstack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .push_data (pc),
        .top       (stk_top),
        .full      (stk_full),
        .empty     (stk_empty),
        .err       (stk_err)
    );

    seq_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op        (op),
        .op_target (op_target),
        .eq_imm    (eq_imm),
        .eq_reg    (eq_reg),
        .stk_top   (stk_top),
        .stk_full  (stk_full),
        .stk_empty (stk_empty),
        .pc        (pc),
        .flag      (flag),
        .halted    (halted),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .res_we    (res_we),
        .res_bit   (res_bit)
    );

    p_res_binary_r5: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (res_data <= DATA_W'(1)));

endmodule

// File: tb/prog_seq_tb.sv
`timescale 1ns/1ps
module prog_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] op_target = '0, op_ra = '0, op_rb = '0, op_imm = '0;
    logic [7:0] pc, res_data;
    logic       flag, halted, stk_err, res_we;

    int n_run = 0;
    int n_fail = 0;

    // Reference state
    logic [7:0] m_pc;
    logic       m_flag, m_halt, m_err, m_we;
    logic [7:0] m_data;
    logic [7:0] m_stk [16];
    int         m_sp;

    always #2 clk = ~clk;

    prog_seq u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_target(op_target), .op_ra(op_ra), .op_rb(op_rb), .op_imm(op_imm),
        .pc(pc), .flag(flag), .halted(halted), .stk_err(stk_err),
        .res_we(res_we), .res_data(res_data)
    );

    task automatic check(input string tag);
        n_run++;
        if (pc !== m_pc || flag !== m_flag || halted !== m_halt ||
            stk_err !== m_err || res_we !== m_we || (m_we && res_data !== m_data)) begin
            n_fail++;
            $display("FAIL %s: pc=%0d/%0d flag=%0b/%0b halt=%0b/%0b err=%0b/%0b we=%0b/%0b data=%0d/%0d (actual/expected)",
                     tag, pc, m_pc, flag, m_flag, halted, m_halt, stk_err, m_err,
                     res_we, m_we, res_data, m_data);
        end
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        op_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pc = '0; m_flag = 1'b0; m_halt = 1'b0; m_err = 1'b0;
        m_we = 1'b0; m_data = '0; m_sp = 0;
        check(tag);
    endtask

    task automatic idle(input string tag);
        op_valid = 1'b0;
        m_we = 1'b0;
        @(negedge clk);
        check(tag);
    endtask

    task automatic model(input logic [3:0] c, input logic [7:0] t, a, b, imm);
        m_we = 1'b0;
        if (m_halt) return;
        case (c)
            4'd1: begin m_flag = (a == imm); m_pc = m_pc + 8'd1; end
            4'd2: begin m_flag = (a == b); m_pc = m_pc + 8'd1; end
            4'd3: begin m_we = 1'b1; m_data = (a == b) ? 8'd1 : 8'd0; m_pc = m_pc + 8'd1; end
            4'd4: m_pc = t;
            4'd5: m_pc = m_flag ? t : m_pc + 8'd1;
            4'd6: m_pc = m_flag ? m_pc + 8'd1 : t;
            4'd7: begin
                if (m_sp == 16) begin m_err = 1'b1; m_pc = m_pc + 8'd1; end
                else begin m_stk[m_sp] = m_pc; m_sp++; m_pc = t; end
            end
            4'd8: begin
                if (m_sp == 0) begin m_err = 1'b1; m_pc = m_pc + 8'd1; end
                else begin m_sp--; m_pc = m_stk[m_sp] + 8'd1; end
            end
            4'd9: begin
                if (m_sp == 0) m_err = 1'b1;
                else m_sp--;
                m_pc = m_pc + 8'd1;
            end
            4'd10: m_halt = 1'b1;
            default: m_pc = m_pc + 8'd1;
        endcase
    endtask

    task automatic op(input logic [3:0] c, input logic [7:0] t, a, b, imm, input string tag);
        op_valid = 1'b1; op_code = c; op_target = t; op_ra = a; op_rb = b; op_imm = imm;
        model(c, t, a, b, imm);
        @(negedge clk);
        op_valid = 1'b0;
        check(tag);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset("R1 reset state");
        idle("R2 idle hold");
        idle("R2 idle hold");
        op(4'd0, 8'd99, 0, 0, 0, "R2 nop step");
        for (int c = 11; c < 16; c++) op(4'(c), 8'd200, 0, 0, 0, "R2 unused code");
        for (int a = 0; a < 16; a++) begin
            op(4'd1, 0, 8'(a), 0, 8'(a), "R3 cmpi equal");
            op(4'd1, 0, 8'(a), 0, 8'(a ^ 1), "R3 cmpi differ");
            op(4'd1, 0, 8'(a), 0, 8'(a + 16), "R3 cmpi high bit");
        end
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) op(4'd2, 0, 8'(a), 8'(b), 0, "R4 cmpr");
        for (int f = 0; f < 2; f++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++) begin
                    op(4'd1, 0, 8'd5, 0, (f == 1) ? 8'd5 : 8'd6, "R3 set flag");
                    op(4'd3, 0, 8'(a), 8'(b), 0, "R5 cmp3");
                end
        idle("R5 result drops");
        for (int t = 0; t < 256; t += 17) op(4'd4, 8'(t), 0, 0, 0, "R6 jump");
        op(4'd4, 8'd255, 0, 0, 0, "R6 jump top");
        op(4'd0, 0, 0, 0, 0, "R2 pc wraps");
        for (int f = 0; f < 2; f++) begin
            op(4'd1, 0, 8'd3, 0, (f == 1) ? 8'd3 : 8'd4, "R3 set flag");
            op(4'd5, 8'd40, 0, 0, 0, "R7 jnz");
            op(4'd6, 8'd80, 0, 0, 0, "R7 jz");
        end
        op(4'd7, 8'd100, 0, 0, 0, "R8 call 1");
        op(4'd7, 8'd150, 0, 0, 0, "R8 call 2");
        op(4'd0, 0, 0, 0, 0, "R2 nop in callee");
        op(4'd7, 8'd30, 0, 0, 0, "R8 call 3");
        op(4'd8, 0, 0, 0, 0, "R8 ret 3");
        op(4'd8, 0, 0, 0, 0, "R8 ret 2");
        op(4'd7, 8'd60, 0, 0, 0, "R8 call again");
        op(4'd9, 0, 0, 0, 0, "R9 discard");
        op(4'd8, 0, 0, 0, 0, "R9 ret after discard");
        idle("R10 no error yet");
        do_reset("R1 reset before fill");
        for (int i = 0; i < 16; i++) op(4'd7, 8'(10 * i + 3), 0, 0, 0, "R8 fill call");
        op(4'd7, 8'd222, 0, 0, 0, "R10 overflow call");
        for (int i = 0; i < 16; i++) op(4'd8, 0, 0, 0, 0, "R8 unwind ret");
        op(4'd8, 0, 0, 0, 0, "R10 underflow ret");
        op(4'd9, 0, 0, 0, 0, "R10 underflow discard");
        do_reset("R1 reset clears error");
        op(4'd9, 0, 0, 0, 0, "R10 discard empty");
        op(4'd1, 0, 8'd7, 0, 8'd7, "R3 flag before halt");
        op(4'd7, 8'd44, 0, 0, 0, "R8 call before halt");
        op(4'd10, 8'd9, 0, 0, 0, "R11 halt");
        op(4'd1, 0, 8'd1, 0, 8'd2, "R11 cmpi ignored");
        op(4'd4, 8'd77, 0, 0, 0, "R11 jump ignored");
        op(4'd3, 0, 8'd1, 8'd1, 0, "R11 cmp3 ignored");
        op(4'd8, 0, 0, 0, 0, "R11 ret ignored");
        op(4'd0, 0, 0, 0, 0, "R11 nop ignored");
        idle("R11 idle halted");
        do_reset("R1 reset leaves halt");
        op(4'd0, 0, 0, 0, 0, "R2 runs after reset");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule